// File: doc/BRIEF.md
# Weighted Deficit Round-Robin Packet Scheduler

This block picks which of several per-flow packet queues may send its head packet next on a shared output link. It sees, for each queue, a non-empty flag and the length of the packet at the head. It keeps a credit balance for each queue. It visits the non-empty queues in turn. On each visit it adds that queue's programmable quantum to the balance. It then releases head packets for as long as each one fits within the balance.

Each release is presented as a grant, made of a queue index and a packet length, on a valid/ready handshake. The queues themselves, and the packet storage behind them, sit outside the block. The environment pops the granted queue when the handshake completes, and the new head length is visible on the following cycle. A queue's share of the link follows its quantum, which gives weighted service.

Top module: `wdrr_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `grant_valid_o` is 0. All credit balances start at zero.
- R2: On each visit, the visited queue's quantum is added to its credit once. A head packet is granted only if its length is less than or equal to the credit. An accepted grant subtracts that length from the credit.
- R3: When the head packet does not fit, the remaining credit is kept for that queue's next visit. For example, a 600-byte head with a quantum of 200 is granted on its third visit.
- R4: While a queue is empty, its credit is forced to zero, so a queue that is refilled starts again from zero.
- R5: Each queue has its own quantum on `quantum_i` (queue i in bits [i*QNT_W +: QNT_W]). The long-run share of the link that a queue receives follows its quantum.
- R6: Only non-empty queues are visited, in increasing index order with wraparound from NQ-1 to 0. A granted queue is non-empty when its grant is raised, and `grant_len_o` equals that queue's head length.
- R7: After an accepted grant, the same queue is served again if its new head fits the remaining credit. Otherwise the scheduler moves on to the next non-empty queue.
- R8: While `grant_valid_o` is 1 and `grant_ready_i` is 0, the grant stays asserted and its index and length do not change.
- R9: If no queue is non-empty, no grant is raised and the round-robin position does not move. The next visit starts from the queue after the last one visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_nonempty_i | input | NQ | Bit i is set when queue i holds at least one packet |
| head_len_i | input | NQ*LEN_W | Head packet length of queue i in bits [i*LEN_W +: LEN_W] |
| quantum_i | input | NQ*QNT_W | Credit added per visit for queue i in bits [i*QNT_W +: QNT_W] |
| grant_valid_o | output | 1 | A grant is offered |
| grant_ready_i | input | 1 | The link accepts the offered grant |
| grant_qid_o | output | IDX_W | Index of the granted queue |
| grant_len_o | output | LEN_W | Length of the granted packet |

## Verification
The hardest case to reach is credit that survives between visits. A queue must be left with leftover credit and then come round again, either still backlogged or after it has drained and been refilled. Whether the leftover is kept or cleared only shows up later, as a change in the order of grants across queues. The stimulus builds this case on purpose: a 600-byte head that needs three visits, and a drained queue refilled beside a busy neighbour. A fixed-seed random run with mixed quanta and lengths follows. Each accepted grant is compared with a packet-level model of the rotation, and the link's ready is stalled at random.

// File: rtl/wdrr_pkg.sv
package wdrr_pkg;
  typedef enum logic [1:0] {
    ST_PICK  = 2'd0,
    ST_SERVE = 2'd1,
    ST_GRANT = 2'd2
  } wdrr_st_e;
endpackage

// File: rtl/wdrr_rr_pick.sv
module wdrr_rr_pick #(
  parameter int NQ    = 4,
  parameter int IDX_W = 2
) (
  input  logic [NQ-1:0]    req_i,
  input  logic [IDX_W-1:0] base_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the nearest request at or after base_i wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = base_i;
    for (int k = NQ - 1; k >= 0; k--) begin
      int j;
      j = int'(base_i) + k;
      if (j >= NQ) j = j - NQ;
      if (req_i[j]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/wdrr_credit.sv
module wdrr_credit #(
  parameter int LEN_W  = 10,
  parameter int QNT_W  = 10,
  parameter int CRED_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [QNT_W-1:0]  quantum_i,
  input  logic              sub_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [CRED_W-1:0] credit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    credit_o <= '0;
    else if (clr_i) credit_o <= '0;
    else if (add_i) credit_o <= credit_o + CRED_W'(quantum_i);
    else if (sub_i) credit_o <= credit_o - CRED_W'(len_i);
  end
endmodule

// File: rtl/wdrr_sched.sv
module wdrr_sched
  import wdrr_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int LEN_W = 10,
  parameter int QNT_W = 10,
  parameter int IDX_W = $clog2(NQ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NQ-1:0]       q_nonempty_i,
  input  logic [NQ*LEN_W-1:0] head_len_i,
  input  logic [NQ*QNT_W-1:0] quantum_i,
  output logic                grant_valid_o,
  input  logic                grant_ready_i,
  output logic [IDX_W-1:0]    grant_qid_o,
  output logic [LEN_W-1:0]    grant_len_o
);
  // credit never exceeds quantum + head length - 1
  localparam int CRED_W = ((LEN_W > QNT_W) ? LEN_W : QNT_W) + 1;

  wdrr_st_e          st_q;
  logic [IDX_W-1:0]  ptr_q, cur_q, sel, nxt_ptr;
  logic              hit, fits;
  logic [NQ-1:0]     add_en, sub_en, clr_en;
  logic [CRED_W-1:0] credit [NQ];
  logic [LEN_W-1:0]  heads  [NQ];
  logic [LEN_W-1:0]  glen_q;
  logic              gv_q;

  wdrr_rr_pick #(.NQ(NQ), .IDX_W(IDX_W)) u_pick (
    .req_i (q_nonempty_i),
    .base_i(ptr_q),
    .hit_o (hit),
    .idx_o (sel)
  );

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assign heads[i]  = head_len_i[i*LEN_W +: LEN_W];
    assign clr_en[i] = !q_nonempty_i[i] && !(st_q == ST_GRANT && cur_q == IDX_W'(i));
    wdrr_credit #(.LEN_W(LEN_W), .QNT_W(QNT_W), .CRED_W(CRED_W)) u_cred (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_en[i]),
      .add_i    (add_en[i]),
      .quantum_i(quantum_i[i*QNT_W +: QNT_W]),
      .sub_i    (sub_en[i]),
      .len_i    (glen_q),
      .credit_o (credit[i])
    );
  end

  assign fits    = CRED_W'(heads[cur_q]) <= credit[cur_q];
  assign nxt_ptr = (cur_q == IDX_W'(NQ - 1)) ? '0 : cur_q + 1'b1;

  always_comb begin
    add_en = '0;
    sub_en = '0;
    if (st_q == ST_PICK && hit) add_en[sel] = 1'b1;
    if (st_q == ST_GRANT && grant_ready_i) sub_en[cur_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PICK;
      ptr_q  <= '0;
      cur_q  <= '0;
      gv_q   <= 1'b0;
      glen_q <= '0;
    end else begin
      unique case (st_q)
        ST_PICK: if (hit) begin
          cur_q <= sel;
          st_q  <= ST_SERVE;
        end
        ST_SERVE: begin
          if (q_nonempty_i[cur_q] && fits) begin
            gv_q   <= 1'b1;
            glen_q <= heads[cur_q];
            st_q   <= ST_GRANT;
          end else begin
            ptr_q <= nxt_ptr;
            st_q  <= ST_PICK;
          end
        end
        ST_GRANT: if (grant_ready_i) begin
          gv_q <= 1'b0;
          st_q <= ST_SERVE;  // head updates before next decision
        end
        default: st_q <= ST_PICK;
      endcase
    end
  end

  assign grant_valid_o = gv_q;
  assign grant_qid_o   = cur_q;
  assign grant_len_o   = glen_q;
endmodule

// File: rtl/wdrr_sched_chk.sv
module wdrr_sched_chk #(
  parameter int NQ    = 4,
  parameter int LEN_W = 10,
  parameter int QNT_W = 10,
  parameter int IDX_W = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NQ-1:0]       q_nonempty_i,
  input logic [NQ*LEN_W-1:0] head_len_i,
  input logic [NQ*QNT_W-1:0] quantum_i,
  input logic                grant_valid_o,
  input logic                grant_ready_i,
  input logic [IDX_W-1:0]    grant_qid_o,
  input logic [LEN_W-1:0]    grant_len_o
);
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !grant_valid_o);

  p_len_matches_head_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> grant_len_o == head_len_i[grant_qid_o*LEN_W +: LEN_W]);

  p_grant_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> q_nonempty_i[grant_qid_o]);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && !grant_ready_i |=>
      grant_valid_o && $stable(grant_qid_o) && $stable(grant_len_o));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_nonempty_i == '0) && !grant_valid_o |=> !grant_valid_o);
endmodule

bind wdrr_sched wdrr_sched_chk #(
  .NQ(NQ), .LEN_W(LEN_W), .QNT_W(QNT_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/wdrr_sched_tb_top.sv
module wdrr_sched_tb_top;
  localparam int NQ = 4, LEN_W = 10, QNT_W = 10, IDX_W = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NQ-1:0]       qv = '0;
  logic [NQ*LEN_W-1:0] heads = '0;
  logic [NQ*QNT_W-1:0] qnt = '0;
  logic                gv, rdy = 1'b0;
  logic [IDX_W-1:0]    gq;
  logic [LEN_W-1:0]    gl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int fq [NQ][$];
  int mq [NQ][$];
  int mdef [NQ];
  int mptr = 0;
  int quanta [NQ];
  int exp_q [$];
  int exp_l [$];

  always #4 clk = ~clk;

  wdrr_sched #(.NQ(NQ), .LEN_W(LEN_W), .QNT_W(QNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .q_nonempty_i(qv), .head_len_i(heads),
    .quantum_i(qnt), .grant_valid_o(gv), .grant_ready_i(rdy),
    .grant_qid_o(gq), .grant_len_o(gl)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive_q();
    for (int i = 0; i < NQ; i++) begin
      qv[i] = fq[i].size() > 0;
      heads[i*LEN_W +: LEN_W] = (fq[i].size() > 0) ? LEN_W'(fq[i][0]) : '0;
      qnt[i*QNT_W +: QNT_W] = QNT_W'(quanta[i]);
    end
  endtask

  // packet-level model of the rotation
  task automatic build_expect();
    for (int i = 0; i < NQ; i++) mq[i] = fq[i];
    forever begin
      int c;
      c = -1;
      for (int k = 0; k < NQ; k++)
        if (c < 0 && mq[(mptr + k) % NQ].size() > 0) c = (mptr + k) % NQ;
      if (c < 0) break;
      mdef[c] += quanta[c];
      while (mq[c].size() > 0 && mq[c][0] <= mdef[c]) begin
        exp_q.push_back(c);
        exp_l.push_back(mq[c][0]);
        mdef[c] -= mq[c][0];
        void'(mq[c].pop_front());
      end
      if (mq[c].size() == 0) mdef[c] = 0;
      mptr = (c + 1) % NQ;
    end
  endtask

  task automatic run(input string req);
    bit pend = 0, held = 0;
    int pq = 0, pl = 0, guard = 0;
    build_expect();
    while ((exp_q.size() > 0 || pend) && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (pend) begin
        void'(fq[pq].pop_front());
        pend = 0;
      end
      drive_q();
      if (held) check(gv && gq == IDX_W'(pq) && gl == LEN_W'(pl), "R8 hold", int'(gl), pl);
      held = 0;
      rdy = ($urandom % 4) != 0;
      if (gv) begin
        pq = int'(gq);
        pl = int'(gl);
        if (rdy) begin
          pend = 1;
          if (exp_q.size() == 0) check(0, {req, " extra grant"}, pq, -1);
          else begin
            check(pq == exp_q[0] && pl == exp_l[0], {req, " order qid"}, pq, exp_q[0]);
            void'(exp_q.pop_front());
            void'(exp_l.pop_front());
          end
        end else held = 1;
      end
    end
    check(exp_q.size() == 0, {req, " drained"}, exp_q.size(), 0);
    rdy = 1'b1;
    repeat (12) begin
      @(negedge clk);
      check(!gv, "R9 idle no grant", int'(gv), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NQ; i++) begin mdef[i] = 0; quanta[i] = 100; end
    drive_q();
    repeat (3) @(negedge clk);
    check(!gv, "R1 grant low in reset", int'(gv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!gv, "R1 grant low after reset", int'(gv), 0);

    // R3: 600-byte head, quantum 200, against a light neighbour
    quanta = '{200, 200, 100, 100};
    fq[0] = {600}; fq[1] = {100, 100, 100, 100};
    @(negedge clk); drive_q(); run("R3 carry");

    // R4: drained queue leaves credit behind, refilled beside a busy queue
    quanta = '{300, 300, 100, 100};
    fq[0] = {100};
    @(negedge clk); drive_q(); run("R4 setup");
    fq[0] = {400}; fq[1] = {300, 300};
    @(negedge clk); drive_q(); run("R4 clear");

    // R5: weighted shares with equal packets
    quanta = '{300, 100, 200, 100};
    for (int i = 0; i < NQ; i++) fq[i] = {100, 100, 100, 100, 100, 100};
    @(negedge clk); drive_q(); run("R5 weight");

    // R6/R7: sparse queues, repeated service within one visit
    quanta = '{50, 400, 50, 250};
    fq[1] = {100, 150, 100, 300}; fq[3] = {200, 50, 60};
    @(negedge clk); drive_q(); run("R6 R7 skip");

    // R2: random quanta and lengths
    for (int s = 0; s < 20; s++) begin
      for (int i = 0; i < NQ; i++) begin
        quanta[i] = 1 + ($urandom % 300);
        if ($urandom % 4 != 0)
          for (int p = 0; p < 3 + int'($urandom % 6); p++)
            fq[i].push_back(1 + ($urandom % 700));
      end
      @(negedge clk); drive_q(); run("R2 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule